// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a small memory-mapped target that turns posted 32-bit doorbell writes into interrupt events. A device signals an interrupt by writing to the frame. The frame works out a shared peripheral interrupt (SPI) number from that write. If the number lies inside the window the frame serves, the frame raises a single-cycle rising-edge pulse on the matching line of its pulse vector. The downstream interrupt controller samples that line as an edge event.

The window is set by two parameters: the lowest SPI served (`BASE_SPI`) and how many SPIs are served (`NUM_SPI`). A valid window has a base of at least 32, a count of at least one, and base plus count of at most 1019. A build parameter selects one of four ways to derive the SPI number:
- absolute data: the write data is the SPI number;
- base-relative data: the write data is added to the window base;
- 32-relative data: the write data is added to 32;
- address-only: the write data is ignored and the SPI number comes from the write address.

A write whose SPI number falls outside the window produces no pulse. Instead it raises a sticky error flag, and a read of the type register clears that flag. Software can read a type word that describes the window, and a fixed identification word.

The doorbell logic is a three-state machine that is loaded on every clock:
- `ST_IDLE`: no doorbell was written in the previous cycle.
- `ST_FIRE`: an accepted doorbell was written in the previous cycle, and the pulse line is driven now.
- `ST_REJECT`: an out-of-window doorbell was written in the previous cycle.

Every state moves to `ST_FIRE` on an in-window doorbell, to `ST_REJECT` on an out-of-window doorbell, and to `ST_IDLE` in a cycle with no doorbell. Back-to-back doorbells therefore chain `ST_FIRE` to `ST_FIRE`.

Top module: `msi_spi_frame`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, every `spi_pulse` bit, `err_flag` and `rd_data` are zero in the cycle that follows.
- R2: A read at byte offset 0x008 returns the type word in the cycle after `rd_en`. Bits [25:16] hold `BASE_SPI`, bits [9:0] hold `NUM_SPI`, and every other bit is zero. With the defaults the word is 0x0028_0010.
- R3: A read at offset 0xFCC returns the `IDENT` parameter. A read at any other offset (for example 0x004 or 0x044) returns zero.
- R4: In absolute mode (`MODE` = `DEC_ABS`), a write at offset 0x040 whose data D lies in [BASE_SPI, BASE_SPI+NUM_SPI) drives `spi_pulse[D-BASE_SPI]` high. The pulse lasts exactly the one cycle after the write, and all other bits stay low.
- R5: A doorbell whose SPI number is below `BASE_SPI`, or at or above `BASE_SPI+NUM_SPI` (including 32-bit data far above the window), produces no pulse. It sets `err_flag` in the cycle after the write.
- R6: `err_flag` stays set until a read of offset 0x008 clears it; it is low in the cycle after that read. If an out-of-window doorbell falls in the same cycle as that read, the flag stays set.
- R7: In the data modes, a write to any offset other than 0x040 (including the type and identification offsets) produces no pulse, leaves `err_flag` unchanged and leaves the type word unchanged.
- R8: Doorbells written in consecutive cycles give pulses in consecutive cycles, each on its own line.
- R9: In base-relative mode (`DEC_OFS_BASE`) the SPI number is data + BASE_SPI. In 32-relative mode (`DEC_OFS_32`) it is data + 32. The pulse index and window check then follow R4 and R5.
- R10: In address-only mode (`DEC_ADDR`) every write is a doorbell and the data is ignored. The SPI number is 32 + (address >> 3), so address bits [2:0] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe; a write completes in each cycle it is high |
| wr_addr | input | AW | Byte offset of the write within the frame |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Byte offset of the read |
| rd_data | output | 32 | Read data, valid in the cycle after `rd_en` |
| spi_pulse | output | NUM_SPI | One-cycle edge pulses, bit i stands for SPI BASE_SPI+i |
| err_flag | output | 1 | Sticky out-of-window doorbell flag |

## Verification
The flag-clearing read of the type register and the setting of `err_flag` by a rejected doorbell can fall in the same clock, because the read and write ports are independent. The bench drives an out-of-window doorbell and a type-register read in the very same cycle. It expects the flag still set afterwards and the type word returned unchanged. A second, lone read then has to clear the flag.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    typedef enum logic [1:0] {
        DEC_ABS      = 2'd0,
        DEC_OFS_BASE = 2'd1,
        DEC_OFS_32   = 2'd2,
        DEC_ADDR     = 2'd3
    } dec_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRE   = 2'd1,
        ST_REJECT = 2'd2
    } door_state_e;

    localparam int TYPE_OFS   = 'h008;
    localparam int DOOR_OFS   = 'h040;
    localparam int IDENT_OFS  = 'hFCC;
    localparam int SPI_FLOOR  = 32;
    localparam int SPI_CEIL   = 1019;

endpackage

// File: rtl/msi_spi_decode.sv
module msi_spi_decode
    import msi_frame_pkg::*;
#(
    parameter int        AW       = 12,
    parameter int        BASE_SPI = 40,
    parameter int        NUM_SPI  = 16,
    parameter dec_mode_e MODE     = DEC_ABS,
    parameter int        IW       = 4
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    output logic          doorbell,
    output logic          in_win,
    output logic [IW-1:0] idx
);
    localparam logic [32:0] LO = 33'(BASE_SPI);
    localparam logic [32:0] HI = 33'(BASE_SPI + NUM_SPI);

    logic [32:0] spi_num;

    // The decoding variant is fixed at build time.
    generate
        if (MODE == DEC_ABS) begin : g_abs
            assign spi_num  = {1'b0, wr_data};
            assign doorbell = wr_en && (wr_addr == AW'(DOOR_OFS));
        end else if (MODE == DEC_OFS_BASE) begin : g_ofs_base
            assign spi_num  = {1'b0, wr_data} + LO;
            assign doorbell = wr_en && (wr_addr == AW'(DOOR_OFS));
        end else if (MODE == DEC_OFS_32) begin : g_ofs_32
            assign spi_num  = {1'b0, wr_data} + 33'(SPI_FLOOR);
            assign doorbell = wr_en && (wr_addr == AW'(DOOR_OFS));
        end else begin : g_addr
            assign spi_num  = 33'(wr_addr[AW-1:3]) + 33'(SPI_FLOOR);
            assign doorbell = wr_en;
        end
    endgenerate

    assign in_win = (spi_num >= LO) && (spi_num < HI);
    assign idx    = IW'(spi_num - LO);

endmodule

// File: rtl/msi_door_fsm.sv
module msi_door_fsm
    import msi_frame_pkg::*;
#(
    parameter int NUM_SPI = 16,
    parameter int IW      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               doorbell,
    input  logic               in_win,
    input  logic [IW-1:0]      idx,
    input  logic               clr_req,
    output logic [NUM_SPI-1:0] spi_pulse,
    output logic               err_flag
);
    door_state_e   state_q, state_d;
    logic [IW-1:0] idx_q;

    always_comb begin
        if (doorbell)
            state_d = in_win ? ST_FIRE : ST_REJECT;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx;
        end
    end

    // A rejection in the same cycle as a clear keeps the flag set.
    always_ff @(posedge clk) begin
        if (rst)
            err_flag <= 1'b0;
        else if (state_d == ST_REJECT)
            err_flag <= 1'b1;
        else if (clr_req)
            err_flag <= 1'b0;
    end

    always_comb begin
        spi_pulse = '0;
        unique case (state_q)
            ST_FIRE:   spi_pulse[idx_q] = 1'b1;
            ST_IDLE:   spi_pulse = '0;
            ST_REJECT: spi_pulse = '0;
            default:   spi_pulse = '0;
        endcase
    end

endmodule

// File: rtl/msi_reg_read.sv
module msi_reg_read
    import msi_frame_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          BASE_SPI = 40,
    parameter int          NUM_SPI  = 16,
    parameter logic [31:0] IDENT    = 32'h0002_0A5B
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          type_rd
);
    localparam logic [31:0] TYPE_WORD = {6'd0, 10'(BASE_SPI), 6'd0, 10'(NUM_SPI)};

    assign type_rd = rd_en && (rd_addr == AW'(TYPE_OFS));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_addr == AW'(TYPE_OFS))
                rd_data <= TYPE_WORD;
            else if (rd_addr == AW'(IDENT_OFS))
                rd_data <= IDENT;
            else
                rd_data <= '0;
        end
    end

endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
    import msi_frame_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          BASE_SPI = 40,
    parameter int          NUM_SPI  = 16,
    parameter dec_mode_e   MODE     = DEC_ABS,
    parameter logic [31:0] IDENT    = 32'h0002_0A5B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_SPI-1:0] spi_pulse,
    output logic               err_flag
);
    localparam int IW = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;

    logic          doorbell;
    logic          in_win;
    logic [IW-1:0] idx;
    logic          type_rd;

    msi_spi_decode #(
        .AW(AW), .BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .MODE(MODE), .IW(IW)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .doorbell(doorbell), .in_win(in_win), .idx(idx)
    );

    msi_door_fsm #(.NUM_SPI(NUM_SPI), .IW(IW)) u_fsm (
        .clk(clk), .rst(rst), .doorbell(doorbell), .in_win(in_win),
        .idx(idx), .clr_req(type_rd), .spi_pulse(spi_pulse), .err_flag(err_flag)
    );

    msi_reg_read #(
        .AW(AW), .BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .IDENT(IDENT)
    ) u_read (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .type_rd(type_rd)
    );

endmodule

// File: rtl/msi_frame_chk.sv
module msi_frame_chk
    import msi_frame_pkg::*;
#(
    parameter int AW      = 12,
    parameter int NUM_SPI = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic               rd_en,
    input logic [AW-1:0]      rd_addr,
    input logic [NUM_SPI-1:0] spi_pulse,
    input logic               err_flag
);
    logic type_read;
    assign type_read = rd_en && (rd_addr == AW'(TYPE_OFS));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (spi_pulse == '0 && !err_flag));

    // R4
    single_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(spi_pulse));

    // R4
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_pulse != '0) |-> $past(wr_en));

    // R5
    err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(wr_en));

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (type_read && !wr_en) |=> !err_flag);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !type_read) |=> err_flag);

endmodule

bind msi_spi_frame msi_frame_chk #(.AW(AW), .NUM_SPI(NUM_SPI)) u_chk (.*);

// File: tb/msi_spi_frame_test.sv
module msi_spi_frame_test;
    import msi_frame_pkg::*;

    localparam int AW = 12;
    localparam int N  = 16;
    localparam logic [31:0] TYPE_EXP  = 32'h0028_0010;
    localparam logic [31:0] IDENT_EXP = 32'h0002_0A5B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          wr_en   [4];
    logic [AW-1:0] wr_addr [4];
    logic [31:0]   wr_data [4];
    logic [N-1:0]  pulse   [4];
    logic          err     [4];
    logic [31:0]   rdat    [4];
    logic          rd_en;
    logic [AW-1:0] rd_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [4*N-1:0] exp_q[$];
    string          tag_q[$];

    msi_spi_frame #(.MODE(DEC_ABS)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_addr(wr_addr[0]), .wr_data(wr_data[0]),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat[0]), .spi_pulse(pulse[0]), .err_flag(err[0]));
    msi_spi_frame #(.MODE(DEC_OFS_BASE)) uut_ob (
        .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_addr(wr_addr[1]), .wr_data(wr_data[1]),
        .rd_en(1'b0), .rd_addr(rd_addr), .rd_data(rdat[1]), .spi_pulse(pulse[1]), .err_flag(err[1]));
    msi_spi_frame #(.MODE(DEC_OFS_32)) uut_o32 (
        .clk(clk), .rst(rst), .wr_en(wr_en[2]), .wr_addr(wr_addr[2]), .wr_data(wr_data[2]),
        .rd_en(1'b0), .rd_addr(rd_addr), .rd_data(rdat[2]), .spi_pulse(pulse[2]), .err_flag(err[2]));
    msi_spi_frame #(.MODE(DEC_ADDR)) uut_ad (
        .clk(clk), .rst(rst), .wr_en(wr_en[3]), .wr_addr(wr_addr[3]), .wr_data(wr_data[3]),
        .rd_en(1'b0), .rd_addr(rd_addr), .rd_data(rdat[3]), .spi_pulse(pulse[3]), .err_flag(err[3]));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic clear_bus();
        for (int k = 0; k < 4; k++) wr_en[k] = 1'b0;
        rd_en = 1'b0;
    endtask

    // Driver: one write, expected pulses for the next cycle go to the scoreboard.
    task automatic wr(input int i, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [N-1:0] e, input string req);
        logic [4*N-1:0] v;
        @(negedge clk);
        clear_bus();
        wr_en[i] = 1'b1; wr_addr[i] = a; wr_data[i] = d;
        v = '0;
        v[i*N +: N] = e;
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        clear_bus();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        clear_bus();
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdat[0];
    endtask

    // Monitor: compares every pulse vector against the scoreboard.
    initial begin
        forever begin
            logic [4*N-1:0] e;
            string t;
            @(posedge clk);
            #2;
            if (!rst) begin
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                end else begin
                    e = '0;
                    t = "R4 quiet";
                end
                for (int k = 0; k < 4; k++)
                    check(t, 32'(pulse[k]), 32'(e[k*N +: N]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        clear_bus();
        rd_addr = '0;
        for (int k = 0; k < 4; k++) begin
            wr_addr[k] = '0; wr_data[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            check("R1 pulse", 32'(pulse[k]), 32'h0);
            check("R1 err", 32'(err[k]), 32'h0);
        end
        check("R1 rd_data", rdat[0], 32'h0);
        rst = 1'b0;

        // R2 / R3 register reads
        rd(12'h008, d); check("R2 type", d, TYPE_EXP);
        rd(12'hFCC, d); check("R3 ident", d, IDENT_EXP);
        rd(12'h004, d); check("R3 undefined", d, 32'h0);
        rd(12'h044, d); check("R3 undefined", d, 32'h0);

        // R4 absolute mode, edges of the window
        wr(0, 12'h040, 32'd40, 16'h0001, "R4 low edge");
        wr(0, 12'h040, 32'd55, 16'h8000, "R4 high edge");
        idle();
        wr(0, 12'h040, 32'd47, 16'h0080, "R4 mid");
        idle(); idle();
        check("R4 no err", 32'(err[0]), 32'h0);

        // R8 consecutive doorbells
        wr(0, 12'h040, 32'd41, 16'h0002, "R8 first");
        wr(0, 12'h040, 32'd42, 16'h0004, "R8 second");
        wr(0, 12'h040, 32'd43, 16'h0008, "R8 third");
        idle();

        // R7 writes elsewhere are ignored
        wr(0, 12'h008, 32'd45, 16'h0000, "R7 type write");
        wr(0, 12'hFCC, 32'd45, 16'h0000, "R7 ident write");
        wr(0, 12'h044, 32'd45, 16'h0000, "R7 other write");
        idle();
        check("R7 err", 32'(err[0]), 32'h0);
        rd(12'h008, d); check("R7 type kept", d, TYPE_EXP);

        // R5 rejects
        wr(0, 12'h040, 32'd39, 16'h0000, "R5 below");
        idle();
        check("R5 err below", 32'(err[0]), 32'h1);
        rd(12'h008, d); check("R6 read word", d, TYPE_EXP);
        check("R6 cleared", 32'(err[0]), 32'h0);
        wr(0, 12'h040, 32'd56, 16'h0000, "R5 above");
        idle();
        check("R5 err above", 32'(err[0]), 32'h1);
        idle(); idle();
        check("R6 sticky", 32'(err[0]), 32'h1);
        rd(12'h008, d);
        wr(0, 12'h040, 32'hFFFF_FFFF, 16'h0000, "R5 huge");
        idle();
        check("R5 err huge", 32'(err[0]), 32'h1);
        rd(12'h008, d);
        check("R6 cleared again", 32'(err[0]), 32'h0);

        // R6 collision: reject and clearing read in the same cycle
        @(negedge clk);
        clear_bus();
        wr_en[0] = 1'b1; wr_addr[0] = 12'h040; wr_data[0] = 32'd39;
        rd_en = 1'b1; rd_addr = 12'h008;
        exp_q.push_back('0); tag_q.push_back("R6 collision quiet");
        @(negedge clk);
        clear_bus();
        check("R6 collision err", 32'(err[0]), 32'h1);
        check("R6 collision word", rdat[0], TYPE_EXP);
        rd(12'h008, d);
        check("R6 lone clear", 32'(err[0]), 32'h0);

        // R9 offset modes
        wr(1, 12'h040, 32'd3,  16'h0008, "R9 base-rel");
        wr(1, 12'h040, 32'd15, 16'h8000, "R9 base-rel top");
        wr(2, 12'h040, 32'd8,  16'h0001, "R9 32-rel");
        wr(2, 12'h040, 32'd23, 16'h8000, "R9 32-rel top");
        idle();
        check("R9 no err ob", 32'(err[1]), 32'h0);
        check("R9 no err o32", 32'(err[2]), 32'h0);
        wr(1, 12'h040, 32'd16, 16'h0000, "R9 base-rel reject");
        wr(2, 12'h040, 32'd7,  16'h0000, "R9 32-rel reject");
        idle();
        check("R9 err ob", 32'(err[1]), 32'h1);
        check("R9 err o32", 32'(err[2]), 32'h1);

        // R10 address-only
        wr(3, 12'h040, 32'hDEAD_BEEF, 16'h0001, "R10 addr 0x40");
        wr(3, 12'h07C, 32'd0,         16'h0080, "R10 low bits ignored");
        wr(3, 12'h0B8, 32'd40,        16'h8000, "R10 top");
        idle();
        check("R10 no err", 32'(err[3]), 32'h0);
        wr(3, 12'h008, 32'd45, 16'h0000, "R10 type addr is doorbell");
        idle();
        check("R10 err low", 32'(err[3]), 32'h1);
        wr(3, 12'h0C0, 32'd45, 16'h0000, "R10 above");
        idle(); idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule